// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external 8K x 8 asynchronous static RAM. The host hands it one word at a time through a valid/ready request port carrying an address, a write flag and write data. The controller turns each request into a timed sequence of chip-select, output-enable and write-enable levels. A read returns its byte with a one-cycle valid pulse. Every phase length is a whole number of clock cycles, worked out at elaboration from nanosecond timing parameters and the clock period.

The sequencing obeys the asynchronous part's rules. The address is latched once per access and never moves while write enable is low. A write happens only while both selects are active and write enable is low. Output enable stays high for the whole write. The controller drives the data bus only after a turn-off allowance inside the write pulse, so the RAM and the controller never drive the bus at the same time.

A standby input parks the RAM in its low-power state by pulling the active-high select low. On leaving standby the controller waits one read-cycle time before it accepts another access.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: During and straight after reset, req_ready is 1, ram_ce_n, ram_oe_n and ram_we_n are 1, and ram_dq_drive and rsp_valid are 0.
- R2: The RAM counts as selected when ram_ce_n is 0 and ram_ce is 1. It is selected in every cycle of an access (the read, write-setup and write-pulse phases) and in no other cycle.
- R3: A read holds ram_oe_n low and ram_we_n high for RD_CYC cycles. The controller samples ram_dq_in on the edge that ends the last of those cycles, and in the next cycle it raises rsp_valid for exactly one cycle with that byte on rsp_rdata.
- R4: A write spends one setup cycle with the RAM selected and ram_we_n high, then holds ram_we_n low for WE_CYC cycles. ram_oe_n stays 1 throughout the write.
- R5: ram_addr changes only on the edge that accepts a request, so it is stable for as long as ram_we_n is low.
- R6: ram_dq_drive is 1 only while ram_we_n is low and ram_oe_n is high. It rises after TURN_CYC cycles of the write pulse and falls together with ram_we_n, so data is driven for WE_CYC-TURN_CYC cycles.
- R7: req_ready falls on acceptance. It stays low through the access and a deselected recovery phase of REC_CYC cycles (RD_CYC+REC_CYC cycles for a read, 1+WE_CYC+REC_CYC for a write). A request held during that time is ignored.
- R8: standby_req is taken only when idle and wins over a request arriving in the same cycle. While it is held, ram_ce is 0 and req_ready is 0. After it is released, req_ready stays low for RD_CYC cycles.
- R9: Cycle counts are ceilings of time over CLK_NS. RD_CYC=ceil(T_RC/CLK) and TURN_CYC=ceil(T_HZ/CLK). WE_CYC is the larger of ceil(T_WP/CLK) and TURN_CYC+ceil(T_DW/CLK). REC_CYC is the largest of TURN_CYC, 1, and ceil(T_WC/CLK)-1-WE_CYC. With the defaults (4 ns clock) this gives 18, 7, 15 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write byte |
| standby_req | input | 1 | Ask for low-power standby |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | DATA_W | Captured read byte |
| ram_addr | output | ADDR_W | RAM address pins |
| ram_ce_n | output | 1 | Active-low chip select |
| ram_ce | output | 1 | Active-high chip select |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_we_n | output | 1 | Active-low write enable |
| ram_dq_out | output | DATA_W | Data toward the RAM |
| ram_dq_drive | output | 1 | Enable for the controller's data drivers |
| ram_dq_in | input | DATA_W | Data from the RAM |

## Verification
The bench's RAM model returns a junk byte until output enable has been low for the full access time. A controller that samples one cycle early therefore reads junk instead of the stored byte. The model records a write only when the pulse and the driven-data window both meet their minimums, so a short strobe or an early data cut-off shows up later as a wrong read-back. The model also reports any address movement during the write pulse and any overlap of drive with output enable. Other tests hold a request across a busy access, and assert standby in the same cycle as a request: a controller that accepted either would write a location that must read back as zero.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_WAKE   = 3'd2,
    ST_RD     = 3'd3,
    ST_WSET   = 3'd4,
    ST_WPULSE = 3'd5,
    ST_REC    = 3'd6
  } seq_state_t;

  // ceiling of a time over the clock period
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned rd_cycles(input int unsigned rc, input int unsigned per);
    return max2(ns_to_cyc(rc, per), 1);
  endfunction

  function automatic int unsigned turn_cycles(input int unsigned hz, input int unsigned per);
    return max2(ns_to_cyc(hz, per), 1);
  endfunction

  // pulse must cover both the minimum width and turn-off plus data setup
  function automatic int unsigned we_cycles(input int unsigned wp, input int unsigned dw,
                                            input int unsigned hz, input int unsigned per);
    return max2(ns_to_cyc(wp, per), turn_cycles(hz, per) + max2(ns_to_cyc(dw, per), 1));
  endfunction

  // deselected tail: bus float time, and whatever the write cycle still needs
  function automatic int unsigned rec_cycles(input int unsigned wc, input int unsigned hz,
                                             input int unsigned we, input int unsigned per);
    int unsigned wc_c;
    int unsigned tail;
    wc_c = ns_to_cyc(wc, per);
    tail = (wc_c > we + 1) ? (wc_c - we - 1) : 0;
    return max2(max2(turn_cycles(hz, per), tail), 1);
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (~&cnt)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC   = 18,
  parameter int unsigned WE_CYC   = 15,
  parameter int unsigned TURN_CYC = 7,
  parameter int unsigned REC_CYC  = 7,
  parameter int unsigned CW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          standby_req,
  input  logic [CW-1:0] cnt,
  output logic          timer_clr,
  output logic          ready,
  output logic          accept,
  output logic          rd_capture,
  output logic          sel_n,
  output logic          sel_hi,
  output logic          oe_n,
  output logic          we_n,
  output logic          drive
);
  seq_state_t state_q, state_d;
  logic [CW-1:0] phase_len;
  logic          phase_done;

  always_comb begin
    unique case (state_q)
      ST_RD:     phase_len = CW'(RD_CYC);
      ST_WAKE:   phase_len = CW'(RD_CYC);
      ST_WPULSE: phase_len = CW'(WE_CYC);
      ST_REC:    phase_len = CW'(REC_CYC);
      default:   phase_len = CW'(1);
    endcase
  end

  assign phase_done = (cnt == phase_len - 1'b1);
  assign ready      = (state_q == ST_IDLE) && !standby_req;
  assign accept     = ready && req_valid;
  assign rd_capture = (state_q == ST_RD) && phase_done;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (standby_req)    state_d = ST_SLEEP;
        else if (req_valid) state_d = req_write ? ST_WSET : ST_RD;
      end
      ST_SLEEP:  if (!standby_req) state_d = ST_WAKE;
      ST_WAKE:   if (phase_done)   state_d = ST_IDLE;
      ST_RD:     if (phase_done)   state_d = ST_REC;
      ST_WSET:                     state_d = ST_WPULSE;
      ST_WPULSE: if (phase_done)   state_d = ST_REC;
      ST_REC:    if (phase_done)   state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  assign timer_clr = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign sel_n  = !((state_q == ST_RD) || (state_q == ST_WSET) || (state_q == ST_WPULSE));
  assign sel_hi = (state_q != ST_SLEEP);
  assign oe_n   = (state_q != ST_RD);
  assign we_n   = (state_q != ST_WPULSE);
  assign drive  = (state_q == ST_WPULSE) && (cnt >= CW'(TURN_CYC));
endmodule

// File: rtl/sram_dq_path.sv
`timescale 1ns/1ps
module sram_dq_path #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              rd_capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] ram_dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rvalid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_capture;
      if (rd_capture) rdata_q <= ram_dq_in;
    end
  end
endmodule

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_NS  = 4,
  parameter int unsigned T_RC_NS = 70,
  parameter int unsigned T_WC_NS = 70,
  parameter int unsigned T_WP_NS = 50,
  parameter int unsigned T_DW_NS = 30,
  parameter int unsigned T_HZ_NS = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              standby_req,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_ce,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_drive,
  input  logic [DATA_W-1:0] ram_dq_in
);
  localparam int unsigned RD_CYC   = rd_cycles(T_RC_NS, CLK_NS);
  localparam int unsigned TURN_CYC = turn_cycles(T_HZ_NS, CLK_NS);
  localparam int unsigned WE_CYC   = we_cycles(T_WP_NS, T_DW_NS, T_HZ_NS, CLK_NS);
  localparam int unsigned REC_CYC  = rec_cycles(T_WC_NS, T_HZ_NS, WE_CYC, CLK_NS);
  localparam int unsigned MAX_CYC  = max2(max2(RD_CYC, WE_CYC), REC_CYC);
  localparam int unsigned CW       = $clog2(MAX_CYC + 1);

  logic [CW-1:0] phase_cnt;
  logic          timer_clr;
  logic          accept;
  logic          rd_capture;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (timer_clr),
    .cnt   (phase_cnt)
  );

  sram_seq_fsm #(
    .RD_CYC(RD_CYC), .WE_CYC(WE_CYC), .TURN_CYC(TURN_CYC),
    .REC_CYC(REC_CYC), .CW(CW)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .standby_req (standby_req),
    .cnt         (phase_cnt),
    .timer_clr   (timer_clr),
    .ready       (req_ready),
    .accept      (accept),
    .rd_capture  (rd_capture),
    .sel_n       (ram_ce_n),
    .sel_hi      (ram_ce),
    .oe_n        (ram_oe_n),
    .we_n        (ram_we_n),
    .drive       (ram_dq_drive)
  );

  sram_dq_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .rd_capture (rd_capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .ram_dq_in  (ram_dq_in),
    .addr_q     (ram_addr),
    .wdata_q    (ram_dq_out),
    .rdata_q    (rsp_rdata),
    .rvalid_q   (rsp_valid)
  );
endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_chk #(
  parameter int unsigned ADDR_W   = 13,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned WE_CYC   = 15,
  parameter int unsigned TURN_CYC = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              rd_capture,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_ce_n,
  input logic              ram_ce,
  input logic              ram_oe_n,
  input logic              ram_we_n,
  input logic              ram_dq_drive,
  input logic [DATA_W-1:0] ram_dq_in
);
  logic [15:0] we_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 we_run_q <= '0;
    else if (ram_we_n)          we_run_q <= '0;
    else if (~&we_run_q)        we_run_q <= we_run_q + 1'b1;
  end

  a_r2_select_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_we_n || !ram_oe_n) |-> (!ram_ce_n && ram_ce));

  a_r3_capture_reported: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |=> (rsp_valid && rsp_rdata == $past(ram_dq_in)));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r4_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> ram_oe_n);

  a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (we_run_q == 16'(WE_CYC)));

  a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_we_n && $past(!ram_we_n)) |-> (ram_addr == $past(ram_addr)));

  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_drive |-> (ram_oe_n && !ram_we_n));

  a_r6_turn_off_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_drive |-> (we_run_q >= 16'(TURN_CYC)));

  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_ce_n && ram_oe_n && ram_we_n && !ram_dq_drive));

  a_r8_standby_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_ce |-> (!req_ready && ram_ce_n));
endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WE_CYC(WE_CYC), .TURN_CYC(TURN_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .accept       (accept),
  .rd_capture   (rd_capture),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_rdata    (rsp_rdata),
  .ram_addr     (ram_addr),
  .ram_ce_n     (ram_ce_n),
  .ram_ce       (ram_ce),
  .ram_oe_n     (ram_oe_n),
  .ram_we_n     (ram_we_n),
  .ram_dq_drive (ram_dq_drive),
  .ram_dq_in    (ram_dq_in)
);

// File: tb/sram_strobe_ctrl_test.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_test;
  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R9: expected cycle counts from the timing numbers
  localparam int PER    = 4;
  localparam int E_RD   = cdiv(70, PER);
  localparam int E_TURN = cdiv(25, PER);
  localparam int E_WE   = imax(cdiv(50, PER), E_TURN + cdiv(30, PER));
  localparam int E_REC  = imax(imax(E_TURN, cdiv(70, PER) - 1 - E_WE), 1);
  localparam int MIN_WP = cdiv(50, PER);
  localparam int MIN_DW = cdiv(30, PER);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, standby_req = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, ram_ce_n, ram_ce, ram_oe_n, ram_we_n, ram_dq_drive;
  logic [7:0]  rsp_rdata, ram_dq_out, ram_dq_in;
  logic [12:0] ram_addr;

  always #2 clk = ~clk;

  sram_strobe_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .standby_req(standby_req), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_ce(ram_ce), .ram_oe_n(ram_oe_n),
    .ram_we_n(ram_we_n), .ram_dq_out(ram_dq_out), .ram_dq_drive(ram_dq_drive),
    .ram_dq_in(ram_dq_in)
  );

  // cycle-accurate RAM model, sampled away from the active edge
  logic [7:0]  mem [8192];
  logic [7:0]  shadow [8192];
  int          we_cnt, drv_cnt, oe_cnt, viol;
  logic        prev_we_n, prev_drive;
  logic [12:0] prev_addr;
  logic [7:0]  prev_dq;
  wire         sel = !ram_ce_n && ram_ce;

  assign ram_dq_in = (sel && !ram_oe_n && ram_we_n && oe_cnt >= E_RD) ? mem[ram_addr] : 8'h5A;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8192; i++) mem[i] = 8'h00;
      we_cnt = 0; drv_cnt = 0; oe_cnt = 0; viol = 0;
      prev_we_n = 1'b1; prev_drive = 1'b0; prev_addr = '0; prev_dq = '0;
    end else begin
      if (!ram_we_n && !prev_we_n && ram_addr != prev_addr) viol++;
      if (ram_dq_drive && sel && !ram_oe_n) viol++;
      if (!ram_we_n && sel) begin
        we_cnt++;
        if (ram_dq_drive) drv_cnt++; else drv_cnt = 0;
      end
      if (ram_we_n && !prev_we_n) begin
        if (we_cnt < MIN_WP || drv_cnt < MIN_DW || !prev_drive) viol++;
        else mem[prev_addr] = prev_dq;
        we_cnt = 0; drv_cnt = 0;
      end
      if (sel && !ram_oe_n && ram_we_n) oe_cnt++; else oe_cnt = 0;
      prev_we_n = ram_we_n; prev_drive = ram_dq_drive;
      prev_addr = ram_addr; prev_dq = ram_dq_out;
    end
  end

  int n_chk = 0, n_bad = 0;
  bit reported = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    report();
  end

  task automatic do_access(input logic wr, input logic [12:0] a, input logic [7:0] d,
                           input bit intrude);
    int k, oe_low, we_low, drv, sel_cyc, rsp_at, busy, oe_in_wr;
    logic first_we, first_sel;
    logic [7:0] got;
    k = 0;
    while (!req_ready && k < 200) begin @(negedge clk); k++; end
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    oe_low = 0; we_low = 0; drv = 0; sel_cyc = 0; rsp_at = 0; busy = 0; oe_in_wr = 0;
    got = '0; first_we = ram_we_n; first_sel = sel;
    k = 1;
    while (!req_ready && k < 200) begin
      busy++;
      if (!ram_oe_n) oe_low++;
      if (!ram_we_n) we_low++;
      if (!ram_we_n && !ram_oe_n) oe_in_wr++;
      if (ram_dq_drive) drv++;
      if (sel) sel_cyc++;
      if (rsp_valid) begin rsp_at = k; got = rsp_rdata; end
      if (intrude && k == 3) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 13'h0F0F; req_wdata = 8'h99;
      end
      if (intrude && k == 8) req_valid = 1'b0;
      @(negedge clk);
      k++;
    end
    if (wr) begin
      check("R4 setup cycle we_n high", first_we, 1);
      check("R2 setup cycle selected", first_sel, 1);
      check("R4 R9 write pulse length", we_low, E_WE);
      check("R4 oe_n low during write", oe_in_wr + oe_low, 0);
      check("R6 R9 data drive cycles", drv, E_WE - E_TURN);
      check("R2 selected cycles (write)", sel_cyc, 1 + E_WE);
      check("R7 R9 busy cycles (write)", busy, 1 + E_WE + E_REC);
      shadow[a] = d;
    end else begin
      check("R3 R9 output enable length", oe_low, E_RD);
      check("R3 rsp_valid cycle", rsp_at, E_RD + 1);
      check("R3 read data", got, shadow[a]);
      check("R3 no write strobe in read", we_low, 0);
      check("R2 selected cycles (read)", sel_cyc, E_RD);
      check("R7 R9 busy cycles (read)", busy, E_RD + E_REC);
    end
  endtask

  // {write, addr, data}
  localparam logic [21:0] VEC [0:10] = '{
    {1'b1, 13'h0000, 8'h11}, {1'b1, 13'h1FFF, 8'hEE}, {1'b1, 13'h0ABC, 8'h3C},
    {1'b0, 13'h0000, 8'h00}, {1'b0, 13'h1FFF, 8'h00}, {1'b0, 13'h0ABC, 8'h00},
    {1'b1, 13'h0ABC, 8'hC3}, {1'b0, 13'h0ABC, 8'h00}, {1'b1, 13'h1000, 8'h00},
    {1'b0, 13'h1000, 8'h00}, {1'b0, 13'h0001, 8'h00}
  };

  initial begin
    int n;
    for (int i = 0; i < 8192; i++) shadow[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", req_ready, 1);
    check("R1 strobes idle in reset", {ram_ce_n, ram_oe_n, ram_we_n}, 3'b111);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", req_ready, 1);
    check("R1 strobes idle after reset", {ram_ce_n, ram_oe_n, ram_we_n}, 3'b111);
    check("R1 drive and rsp_valid low", {ram_dq_drive, rsp_valid}, 2'b00);

    for (int i = 0; i < 11; i++) do_access(VEC[i][21], VEC[i][20:8], VEC[i][7:0], 1'b0);

    // R7: request held while busy must be ignored
    do_access(1'b1, 13'h0404, 8'h5C, 1'b1);
    do_access(1'b0, 13'h0404, 8'h00, 1'b0);
    do_access(1'b0, 13'h0404 ^ 13'h0F0F, 8'h00, 1'b0);

    // R8: standby wins over a simultaneous request
    @(negedge clk);
    standby_req = 1'b1; req_valid = 1'b1; req_write = 1'b1;
    req_addr = 13'h0100; req_wdata = 8'h77;
    @(negedge clk);
    check("R8 standby drops ram_ce", ram_ce, 0);
    check("R8 ready low in standby", req_ready, 0);
    n = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!ram_ce_n || ram_ce) n++;
    end
    check("R8 R2 stays deselected in standby", n, 0);
    standby_req = 1'b0; req_valid = 1'b0;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (req_ready) break;
      n++;
    end
    check("R8 R9 wake wait cycles", n, E_RD);
    check("R8 ram_ce back high", ram_ce, 1);
    do_access(1'b0, 13'h0100, 8'h00, 1'b0);

    check("R5 R6 model protocol violations", viol, 0);
    report();
  end
endmodule